// File: doc/BRIEF.md
# Zero-Suppressed Multi-Trigger Event Buffer

This block sits on a 32-channel front-end digitizer board. Each level-1 trigger arrives with a hit map, one bit per channel, and a 16-bit sample for every channel. For each accepted trigger the block packs a record into a shared 32-bit word ring. The record is one header word, then one word per hit channel in ascending channel order, then one tail word. Channels whose hit bit is clear produce nothing, so the ring only carries data that was actually seen.

Records from many triggers are collected into one counted block. The host writes a trigger threshold. When that many records have been completed, the block raises a data-ready flag and an interrupt, both held until the host pulses acknowledge. The running word count tells the host how long a block transfer to issue. The host drains the ring through its own read pointer, so records built while a drain is in progress land after the words already stored.

A trigger is refused when the ring cannot hold a worst-case record, or when a record is still being packed. A refused trigger sets a sticky overflow flag.

Top module: `zs_event_buffer`

## Requirements
- R1: After reset, rd_avail_o, busy_o, data_ready_o, irq_o and overflow_o are 0 and word_count_o is 0.
- R2: The header word is 8'hA5 in bits 31:24 and the trigger number in bits 23:0. The trigger number starts at 0 after reset and advances by one for every trigger presented, accepted or refused.
- R3: Each hit word holds the channel's sample in bits 31:16 and the channel number in bits 15:0. Hit words are written only for channels whose hit-map bit is 1, in ascending channel order.
- R4: The tail word is 8'h5A in bits 31:24, zero in bits 23:8 and the record's hit count in bits 7:0. An all-zero hit map still yields a header and a tail.
- R5: word_count_o equals the number of words written into the ring since reset or the last acknowledge.
- R6: data_ready_o and irq_o rise when the number of records completed since the last acknowledge reaches thresh_i (a value of 0 counts as 1). They then stay high until ack_i.
- R7: An ack_i pulse clears the word count, the record count, data_ready_o, irq_o and overflow_o. A word or record completed in the same cycle as the acknowledge is counted in the new block.
- R8: A trigger is refused when fewer than N_CH+2 words are free in the ring. The refusal sets overflow_o, which stays set until ack_i.
- R9: A trigger that arrives while busy_o is high is refused and sets overflow_o.
- R10: While rd_avail_o is high, rd_data_o shows the oldest unread word, and rd_en_i removes it. rd_en_i while the ring is empty has no effect. Words are read out in the order they were written.
- R11: An accepted trigger with k hits holds busy_o high for exactly k+2 cycles, starting the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Level-1 trigger strobe, one cycle |
| hit_map_i | input | N_CH | Hit bit per channel, sampled with trig_i |
| samples_i | input | N_CH*16 | Channel c sample at bits c*16 +: 16 |
| thresh_i | input | THR_W | Records per block before data ready |
| ack_i | input | 1 | Host acknowledge pulse |
| rd_en_i | input | 1 | Pop the oldest ring word |
| rd_data_o | output | 32 | Oldest unread ring word |
| rd_avail_o | output | 1 | Ring holds at least one word |
| busy_o | output | 1 | A record is being packed |
| word_count_o | output | CNT_W | Words written in the current block |
| data_ready_o | output | 1 | Block threshold reached |
| irq_o | output | 1 | Interrupt request to the host |
| overflow_o | output | 1 | Sticky trigger-refused flag |

## Verification
Two functions can meet in one cycle: the host acknowledge and the tail write that completes a record. The bench places ack_i exactly on the edge where a two-hit record writes its tail, with a threshold of 2. It then expects a word count of 1 and data ready still low. A second record must then raise data ready, which shows that the record completed under the acknowledge was kept in the new block. Host draining that overlaps record packing is also run throughout, and the scoreboard judges it by the order of the words.

// File: rtl/zs_pkg.sv
package zs_pkg;
  localparam int WORD_W   = 32;
  localparam int SAMPLE_W = 16;
  localparam logic [7:0] HDR_MARK  = 8'hA5;
  localparam logic [7:0] TAIL_MARK = 8'h5A;

  typedef enum logic [1:0] {PK_IDLE, PK_HDR, PK_SCAN} pk_state_e;

  function automatic logic [WORD_W-1:0] hdr_word(logic [23:0] num);
    return {HDR_MARK, num};
  endfunction

  function automatic logic [WORD_W-1:0] tail_word(logic [7:0] cnt);
    return {TAIL_MARK, 16'h0000, cnt};
  endfunction

  function automatic logic [WORD_W-1:0] hit_word(logic [15:0] smp, logic [15:0] ch);
    return {smp, ch};
  endfunction
endpackage

// File: rtl/zs_hit_scan.sv
module zs_hit_scan #(
  parameter int N_CH = 32,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0] mask_i,
  output logic            found_o,
  output logic [CH_W-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        found_o = 1'b1;
        idx_o   = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/zs_record_packer.sv
module zs_record_packer
  import zs_pkg::*;
#(
  parameter int N_CH  = 32,
  parameter int NUM_W = 24,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [N_CH-1:0]          map_i,
  input  logic [N_CH*SAMPLE_W-1:0] samples_i,
  input  logic [NUM_W-1:0]         num_i,
  output logic                     busy_o,
  output logic                     wr_en_o,
  output logic [WORD_W-1:0]        wr_data_o,
  output logic                     rec_done_o
);
  pk_state_e                state_q;
  logic [N_CH-1:0]          mask_q;
  logic [N_CH*SAMPLE_W-1:0] samp_q;
  logic [NUM_W-1:0]         num_q;
  logic [7:0]               hits_q;
  logic                     found;
  logic [CH_W-1:0]          idx;
  logic                     hit_wr;

  zs_hit_scan #(.N_CH(N_CH)) u_scan (
    .mask_i (mask_q),
    .found_o(found),
    .idx_o  (idx)
  );

  assign busy_o = (state_q != PK_IDLE);
  assign hit_wr = (state_q == PK_SCAN) && found;

  always_comb begin
    wr_en_o    = 1'b0;
    wr_data_o  = '0;
    rec_done_o = 1'b0;
    case (state_q)
      PK_HDR: begin
        wr_en_o   = 1'b1;
        wr_data_o = hdr_word(24'(num_q));
      end
      PK_SCAN: begin
        wr_en_o = 1'b1;
        if (found) begin
          wr_data_o = hit_word(samp_q[int'(idx)*SAMPLE_W +: SAMPLE_W], 16'(idx));
        end else begin
          wr_data_o  = tail_word(hits_q);
          rec_done_o = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PK_IDLE;
      mask_q  <= '0;
      samp_q  <= '0;
      num_q   <= '0;
      hits_q  <= '0;
    end else begin
      case (state_q)
        PK_IDLE: if (start_i) begin
          mask_q  <= map_i;
          samp_q  <= samples_i;
          num_q   <= num_i;
          hits_q  <= '0;
          state_q <= PK_HDR;
        end
        PK_HDR: state_q <= PK_SCAN;
        PK_SCAN: begin
          if (found) begin
            mask_q[idx] <= 1'b0;
            hits_q      <= hits_q + 8'd1;
          end else begin
            state_q <= PK_IDLE;
          end
        end
        default: state_q <= PK_IDLE;
      endcase
    end
  end

  // R2
  hdr_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q == PK_IDLE) |=> (wr_en_o && wr_data_o[31:24] == HDR_MARK));

  // R3
  ascending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_wr && $past(hit_wr)) |-> (wr_data_o[15:0] > $past(wr_data_o[15:0])));

  // R11
  idle_after_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_done_o |=> !busy_o);
endmodule

// File: rtl/zs_word_ring.sv
module zs_word_ring
  import zs_pkg::*;
#(
  parameter int DEPTH   = 128,
  parameter int RESERVE = 34,
  localparam int AW    = $clog2(DEPTH),
  localparam int OCC_W = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_avail_o,
  output logic              room_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [OCC_W-1:0]  occ_q;
  logic              rd_ok;

  assign rd_avail_o = (occ_q != '0);
  assign rd_ok      = rd_en_i && rd_avail_o;
  assign rd_data_o  = mem_q[rd_ptr_q];
  assign room_o     = (occ_q <= OCC_W'(DEPTH - RESERVE));

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (rd_ok)   rd_ptr_q <= rd_ptr_q + AW'(1);
      occ_q <= occ_q + OCC_W'(wr_en_i) - OCC_W'(rd_ok);
    end
  end

  // R8
  no_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (occ_q < OCC_W'(DEPTH)));

  // R10
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_avail_o && !wr_en_i) |=> !rd_avail_o);
endmodule

// File: rtl/zs_block_ctrl.sv
module zs_block_ctrl #(
  parameter int CNT_W = 16,
  parameter int THR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rec_done_i,
  input  logic             refuse_i,
  input  logic             ack_i,
  input  logic [THR_W-1:0] thresh_i,
  output logic [CNT_W-1:0] word_count_o,
  output logic             ready_o,
  output logic             overflow_o
);
  logic [CNT_W-1:0] wcnt_q, wcnt_base;
  logic [THR_W-1:0] rcnt_q, rcnt_base, rcnt_d, eff_thr;
  logic             ready_q, ovf_q;

  assign eff_thr   = (thresh_i == '0) ? THR_W'(1) : thresh_i;
  assign wcnt_base = ack_i ? '0 : wcnt_q;
  assign rcnt_base = ack_i ? '0 : rcnt_q;
  assign rcnt_d    = (rec_done_i && rcnt_base != '1) ? rcnt_base + THR_W'(1) : rcnt_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q  <= '0;
      rcnt_q  <= '0;
      ready_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      wcnt_q  <= wcnt_base + CNT_W'(wr_en_i);
      rcnt_q  <= rcnt_d;
      ready_q <= (ready_q && !ack_i) || (rec_done_i && rcnt_d >= eff_thr);
      ovf_q   <= (ovf_q && !ack_i) || refuse_i;
    end
  end

  assign word_count_o = wcnt_q;
  assign ready_o      = ready_q;
  assign overflow_o   = ovf_q;

  // R6
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !ack_i) |=> ready_o);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !ack_i) |=> overflow_o);

  // R7
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !wr_en_i) |=> (word_count_o == '0));

  // R5
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_i && wr_en_i && word_count_o != '1) |=> (word_count_o == $past(word_count_o) + CNT_W'(1)));
endmodule

// File: rtl/zs_event_buffer.sv
module zs_event_buffer
  import zs_pkg::*;
#(
  parameter int N_CH  = 32,
  parameter int DEPTH = 128,
  parameter int THR_W = 8,
  parameter int CNT_W = 16,
  parameter int NUM_W = 24,
  localparam int REC_MAX = N_CH + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     trig_i,
  input  logic [N_CH-1:0]          hit_map_i,
  input  logic [N_CH*SAMPLE_W-1:0] samples_i,
  input  logic [THR_W-1:0]         thresh_i,
  input  logic                     ack_i,
  input  logic                     rd_en_i,
  output logic [WORD_W-1:0]        rd_data_o,
  output logic                     rd_avail_o,
  output logic                     busy_o,
  output logic [CNT_W-1:0]         word_count_o,
  output logic                     data_ready_o,
  output logic                     irq_o,
  output logic                     overflow_o
);
  logic [NUM_W-1:0]  trig_num_q;
  logic              room, accept, refuse;
  logic              wr_en, rec_done;
  logic [WORD_W-1:0] wr_data;

  assign accept = trig_i && !busy_o && room;
  assign refuse = trig_i && !accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     trig_num_q <= '0;
    else if (trig_i) trig_num_q <= trig_num_q + NUM_W'(1);
  end

  zs_record_packer #(.N_CH(N_CH), .NUM_W(NUM_W)) u_packer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .map_i     (hit_map_i),
    .samples_i (samples_i),
    .num_i     (trig_num_q),
    .busy_o    (busy_o),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data),
    .rec_done_o(rec_done)
  );

  zs_word_ring #(.DEPTH(DEPTH), .RESERVE(REC_MAX)) u_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .rd_avail_o(rd_avail_o),
    .room_o    (room)
  );

  zs_block_ctrl #(.CNT_W(CNT_W), .THR_W(THR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .rec_done_i  (rec_done),
    .refuse_i    (refuse),
    .ack_i       (ack_i),
    .thresh_i    (thresh_i),
    .word_count_o(word_count_o),
    .ready_o     (data_ready_o),
    .overflow_o  (overflow_o)
  );

  assign irq_o = data_ready_o;

  // R9
  busy_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && busy_o) |=> overflow_o);

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!busy_o && !rd_avail_o));
endmodule

// File: tb/zs_event_buffer_test.sv
module zs_event_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              trig = 1'b0;
  logic [N_CH-1:0]   hit_map = '0;
  logic [N_CH*16-1:0] samples = '0;
  logic [7:0]        thresh = 8'd1;
  logic              ack = 1'b0;
  logic              rd_en_mon = 1'b0;
  logic              force_rd = 1'b0;
  logic [31:0]       rd_data;
  logic              rd_avail, busy, data_ready, irq, overflow;
  logic [15:0]       word_count;

  int checks = 0;
  int errors = 0;
  bit drain = 1'b0;
  logic [23:0] tn = '0;
  logic [31:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  zs_event_buffer uut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .hit_map_i(hit_map),
    .samples_i(samples), .thresh_i(thresh), .ack_i(ack),
    .rd_en_i(rd_en_mon | force_rd), .rd_data_o(rd_data), .rd_avail_o(rd_avail),
    .busy_o(busy), .word_count_o(word_count), .data_ready_o(data_ready),
    .irq_o(irq), .overflow_o(overflow)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: compare and pop one word per cycle
  always @(negedge clk) begin
    rd_en_mon = 1'b0;
    if (rst_n && drain && rd_avail) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected word", rd_data, 32'h0);
      end else begin
        logic [31:0] w;
        w = exp_q.pop_front();
        chk(rd_data === w, "R2/R3/R4/R10", "ring word", rd_data, w);
      end
      rd_en_mon = 1'b1;
    end
  end

  function automatic int popc(logic [31:0] m);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(m[i]);
    return n;
  endfunction

  task automatic push_record(input logic [31:0] map, input logic [15:0] base);
    int k = 0;
    exp_q.push_back({8'hA5, tn});
    for (int c = 0; c < N_CH; c++) begin
      if (map[c]) begin
        exp_q.push_back({base + 16'(c) * 16'h0101, 16'(c)});
        k++;
      end
    end
    exp_q.push_back({8'h5A, 16'h0000, 8'(k)});
  endtask

  task automatic set_inputs(input logic [31:0] map, input logic [15:0] base);
    hit_map = map;
    for (int c = 0; c < N_CH; c++) samples[c*16 +: 16] = base + 16'(c) * 16'h0101;
  endtask

  // drive one trigger; expect acceptance or refusal; checks busy duration (R11)
  task automatic fire(input logic [31:0] map, input logic [15:0] base, input bit accepted);
    int cyc = 0;
    set_inputs(map, base);
    if (accepted) push_record(map, base);
    trig = 1'b1;
    tn = tn + 24'd1;
    @(negedge clk);
    trig = 1'b0;
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
    chk(cyc == (accepted ? popc(map) + 2 : 0), "R11", "busy cycles", cyc, accepted ? popc(map) + 2 : 0);
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic wait_drained();
    while (exp_q.size() != 0 || rd_avail) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!rd_avail && !busy && !data_ready && !irq && !overflow, "R1", "idle flags",
        {rd_avail, busy, data_ready, irq, overflow}, 0);
    chk(word_count == 0, "R1", "word count", word_count, 0);

    thresh = 8'd3;
    drain = 1'b1;
    fire(32'h0000_0001, 16'h1000, 1'b1);
    chk(word_count == 3, "R5", "count after rec1", word_count, 3);
    chk(!data_ready, "R6", "ready below thresh", data_ready, 0);
    fire(32'h8000_0001, 16'h2000, 1'b1);
    chk(word_count == 7, "R5", "count after rec2", word_count, 7);
    fire(32'h0000_0000, 16'h3000, 1'b1);  // R4 empty record
    chk(word_count == 9, "R4", "empty map words", word_count, 9);
    chk(data_ready && irq, "R6", "ready at thresh", {data_ready, irq}, 2'b11);
    repeat (5) @(negedge clk);
    chk(data_ready && irq, "R6", "ready held", {data_ready, irq}, 2'b11);
    fire(32'h1234_5678, 16'h4000, 1'b1);  // R3 scattered hits, appended while draining
    chk(word_count == 24, "R5", "count after rec4", word_count, 24);
    pulse_ack();
    chk(word_count == 0 && !data_ready && !irq, "R7", "ack clears",
        {word_count, data_ready, irq}, 0);
    wait_drained();

    // R10 empty read ignored
    force_rd = 1'b1;
    repeat (3) @(negedge clk);
    force_rd = 1'b0;
    chk(!rd_avail, "R10", "empty after reads", rd_avail, 0);
    thresh = 8'd1;
    fire(32'hFFFF_FFFF, 16'h5000, 1'b1);
    chk(word_count == 34 && data_ready, "R6", "full record thresh 1",
        {word_count, data_ready}, {16'd34, 1'b1});
    pulse_ack();
    wait_drained();

    // R9 trigger while busy
    set_inputs(32'h0000_0F00, 16'h6000);
    push_record(32'h0000_0F00, 16'h6000);
    trig = 1'b1;
    tn = tn + 24'd1;
    @(negedge clk);
    tn = tn + 24'd1;
    @(negedge clk);
    trig = 1'b0;
    while (busy) @(negedge clk);
    chk(overflow, "R9", "busy refusal", overflow, 1);
    chk(word_count == 6, "R9", "only one record", word_count, 6);
    pulse_ack();
    chk(!overflow, "R7", "ack clears overflow", overflow, 0);
    wait_drained();

    // R6 threshold zero acts as one
    thresh = 8'd0;
    fire(32'h0000_0010, 16'h7000, 1'b1);
    chk(data_ready, "R6", "thresh zero", data_ready, 1);
    pulse_ack();
    wait_drained();

    // R7 ack on the tail edge
    thresh = 8'd2;
    set_inputs(32'h0000_0003, 16'h8000);
    push_record(32'h0000_0003, 16'h8000);
    trig = 1'b1;
    tn = tn + 24'd1;
    @(negedge clk);
    trig = 1'b0;
    repeat (3) @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(word_count == 1, "R7", "tail counted after ack", word_count, 1);
    chk(!data_ready, "R7", "one record in block", data_ready, 0);
    fire(32'h0000_0000, 16'h9000, 1'b1);
    chk(data_ready && word_count == 3, "R7", "record kept across ack",
        {data_ready, word_count}, {1'b1, 16'd3});
    pulse_ack();
    wait_drained();

    // R8 ring fill
    drain = 1'b0;
    thresh = 8'd8;
    fire(32'hFFFF_FFFF, 16'hA000, 1'b1);
    fire(32'hFFFF_FFFF, 16'hB000, 1'b1);
    fire(32'hFFFF_FFFF, 16'hC000, 1'b1);
    chk(!overflow, "R8", "no overflow yet", overflow, 0);
    fire(32'h0000_0001, 16'hD000, 1'b0);
    chk(overflow, "R8", "refused when full", overflow, 1);
    chk(word_count == 102, "R8", "count unchanged", word_count, 102);
    chk(rd_avail, "R10", "data held", rd_avail, 1);
    drain = 1'b1;
    wait_drained();
    fire(32'h0000_0002, 16'hE000, 1'b1);
    chk(overflow, "R8", "overflow sticky", overflow, 1);
    wait_drained();
    pulse_ack();
    chk(!overflow && word_count == 0, "R7", "ack clears block",
        {overflow, word_count}, 0);
    chk(exp_q.size() == 0, "R10", "scoreboard empty", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule